// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Operation Decoder

This block is the arithmetic core of a small multi-cycle processor with a parameterized data width (8 bits by default). It has two parts. A decoder turns a 2-bit operation class from the processor's controller, together with the 6-bit function field of register-type instructions, into a 3-bit operation code. An execution path then applies that code to two operands and produces a result and a zero flag.

The execution path supports AND, OR, add, subtract and signed set-less-than. One ripple adder serves add, subtract and set-less-than. For subtract, the adder sees the bitwise complement of B and a carry-in of one. Set-less-than runs the same subtraction and returns the sign bit of the difference as a one-bit result. The zero flag reports an all-zero result, and the processor uses it to decide branch-if-equal.

The block is purely combinational. It has no clock, no reset and no handshake. Outputs settle from the present inputs, and the controller samples them in whatever cycle it chooses. Because no data is buffered, there is no back-pressure to manage.

Top module: `alu_core`

## Requirements
- R1: With operation class 00, the operation code is 3'b010 (add), and result equals (a + b) modulo 2^WIDTH, whatever the function field holds.
- R2: With operation class 01, the operation code is 3'b110 (subtract), and result equals (a - b) modulo 2^WIDTH, whatever the function field holds.
- R3: With operation class 10 or 11, function 6'b100000 gives add (code 3'b010), and function 6'b100010 gives subtract (code 3'b110).
- R4: With operation class 1x, function 6'b100100 gives code 3'b000, and result equals a & b.
- R5: With operation class 1x, function 6'b100101 gives code 3'b001, and result equals a | b.
- R6: With operation class 1x, function 6'b101010 gives code 3'b111. Result bit 0 equals the top bit of (a - b) modulo 2^WIDTH, with no correction for signed overflow, and every other result bit is 0.
- R7: With operation class 1x, any function value not listed in R3 to R6 gives code 3'b010, and result equals a + b.
- R8: The zero output is 1 exactly when every result bit is 0. This holds for every operation, including set-less-than and the logical operations.
- R9: Code layout: bit 2 selects inversion of B together with a carry-in of one. Bits 1:0 select the output: 00 AND, 01 OR, 10 adder sum, 11 set-less-than. All outputs follow the inputs combinationally, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class from the controller |
| funct | input | 6 | Function field of the instruction (bits 5:0) |
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| alu_ctl | output | 3 | Decoded operation code |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The assertions assume every input bit is a known 0 or 1. They also assume the function field matters only when the operation-class top bit is set. The stimulus drives all four operation classes and always loads fully defined random values into every operand and function bit. It mixes the five defined function codes with arbitrary six-bit values, so both the decode and the default path of R7 are reached. Directed cases add the zero-result, equal-operand and signed-overflow corners of set-less-than.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_SLT = 2'b11
  } alu_sel_e;

  typedef struct packed {
    logic     inv_b;
    alu_sel_e sel;
  } alu_ctl_t;

  localparam logic [1:0] CLS_ADD = 2'b00;
  localparam logic [1:0] CLS_SUB = 2'b01;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/alu_func_decode.sv
module alu_func_decode
  import alu_pkg::*;
(
  input  logic [1:0] op_class,
  input  logic [5:0] funct,
  output alu_ctl_t   ctl
);
  alu_ctl_t fn_ctl;

  // function-field decode, unlisted codes fall back to add
  always_comb begin
    unique case (funct)
      FN_SUB:  fn_ctl = '{inv_b: 1'b1, sel: SEL_SUM};
      FN_AND:  fn_ctl = '{inv_b: 1'b0, sel: SEL_AND};
      FN_OR:   fn_ctl = '{inv_b: 1'b0, sel: SEL_OR};
      FN_SLT:  fn_ctl = '{inv_b: 1'b1, sel: SEL_SLT};
      default: fn_ctl = '{inv_b: 1'b0, sel: SEL_SUM};
    endcase
  end

  always_comb begin
    unique case (op_class)
      CLS_ADD: ctl = '{inv_b: 1'b0, sel: SEL_SUM};
      CLS_SUB: ctl = '{inv_b: 1'b1, sel: SEL_SUM};
      default: ctl = fn_ctl;
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             inv_b,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] carry;
  logic [WIDTH-1:0] bx;

  assign carry[0] = inv_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bx[i]  = b[i] ^ inv_b;
    assign sum[i] = a[i] ^ bx[i] ^ carry[i];
    if (i < WIDTH - 1) begin : g_carry
      assign carry[i+1] = (a[i] & bx[i]) | (carry[i] & (a[i] ^ bx[i]));
    end
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);
  logic [WIDTH-1:0] any_set;

  assign any_set[0] = value[0];
  for (genvar i = 1; i < WIDTH; i++) begin : g_or
    assign any_set[i] = any_set[i-1] | value[i];
  end

  assign is_zero = ~any_set[WIDTH-1];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       op_class,
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [2:0]       alu_ctl,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  alu_ctl_t         ctl;
  logic [WIDTH-1:0] sum;

  alu_func_decode u_dec (
    .op_class (op_class),
    .funct    (funct),
    .ctl      (ctl)
  );

  alu_adder #(.WIDTH(WIDTH)) u_add (
    .a     (a),
    .b     (b),
    .inv_b (ctl.inv_b),
    .sum   (sum)
  );

  always_comb begin
    unique case (ctl.sel)
      SEL_AND: result = a & b;
      SEL_OR:  result = a | b;
      SEL_SUM: result = sum;
      default: result = {{(WIDTH-1){1'b0}}, sum[MSB]};
    endcase
  end

  alu_zero_detect #(.WIDTH(WIDTH)) u_zd (
    .value   (result),
    .is_zero (zero)
  );

  assign alu_ctl = ctl;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 8
) (
  input logic [1:0]       op_class,
  input logic [5:0]       funct,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [2:0]       alu_ctl,
  input logic [WIDTH-1:0] result,
  input logic             zero
);
  always_comb begin
    assert_class_add_R1: assert (op_class != 2'b00 || alu_ctl == 3'b010);
    assert_class_sub_R2: assert (op_class != 2'b01 || alu_ctl == 3'b110);
    assert_and_code_R4: assert (!(op_class[1] && funct == 6'b100100) || alu_ctl == 3'b000);
    assert_and_subset_R4: assert (alu_ctl != 3'b000 || (result & ~a) == '0);
    assert_or_superset_R5: assert (alu_ctl != 3'b001 || (result & a) == a);
    assert_slt_narrow_R6: assert (alu_ctl != 3'b111 || result[WIDTH-1:1] == '0);
    assert_default_add_R7: assert (!(op_class[1] && funct[5:4] != 2'b10) || alu_ctl == 3'b010);
    assert_zero_flag_R8: assert (zero == (result == '0));
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .op_class (op_class),
  .funct    (funct),
  .a        (a),
  .b        (b),
  .alu_ctl  (alu_ctl),
  .result   (result),
  .zero     (zero)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]   op_class;
  logic [5:0]   funct;
  logic [W-1:0] a, b;
  logic [2:0]   alu_ctl;
  logic [W-1:0] result;
  logic         zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alu_core #(.WIDTH(W)) u0 (
    .op_class (op_class), .funct (funct), .a (a), .b (b),
    .alu_ctl (alu_ctl), .result (result), .zero (zero)
  );

  // kinds: 0 add, 1 sub, 2 and, 3 or, 4 slt
  function automatic int kind_of(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 0;
    if (c == 2'b01) return 1;
    case (f)
      6'b100010: return 1;
      6'b100100: return 2;
      6'b100101: return 3;
      6'b101010: return 4;
      default:   return 0;
    endcase
  endfunction

  function automatic logic [2:0] exp_ctl(input int k);
    case (k)
      1: return 3'b110;
      2: return 3'b000;
      3: return 3'b001;
      4: return 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_res(input int k, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] d;
    d = x - y;
    case (k)
      1: return d;
      2: return x & y;
      3: return x | y;
      4: return {{(W-1){1'b0}}, d[W-1]};
      default: return x + y;
    endcase
  endfunction

  function automatic string tag_of(input int k, input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return "R1";
    if (c == 2'b01) return "R2";
    if (f == 6'b100000 || f == 6'b100010) return "R3";
    case (k)
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [1:0] c, input logic [5:0] f,
                       input logic [W-1:0] x, input logic [W-1:0] y);
    int k;
    logic [W-1:0] er;
    string t;
    @(negedge clk);
    op_class = c; funct = f; a = x; b = y;
    #1; // R9: no clock edge between stimulus and sample
    k  = kind_of(c, f);
    er = exp_res(k, x, y);
    t  = tag_of(k, c, f);
    checks++;
    if (alu_ctl !== exp_ctl(k)) begin
      fails++;
      $display("FAIL %s/R9 ctl: got %b expected %b (cls %b fn %b)", t, alu_ctl, exp_ctl(k), c, f);
    end
    checks++;
    if (result !== er) begin
      fails++;
      $display("FAIL %s result: got %h expected %h (cls %b fn %b a %h b %h)", t, result, er, c, f, x, y);
    end
    checks++;
    if (zero !== (er == '0)) begin
      fails++;
      $display("FAIL R8 zero: got %b expected %b (result %h)", zero, (er == '0), er);
    end
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  localparam logic [5:0] FN [5] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};

  initial begin
    void'($urandom(32'd20240611));
    // idle state: all inputs zero, R1 add of zeros, R8 zero set
    apply(2'b00, 6'b000000, 8'h00, 8'h00);
    // R1 ignores funct, wrap-around
    apply(2'b00, 6'b101010, 8'hFF, 8'h01);
    // R2 ignores funct, borrow
    apply(2'b01, 6'b100100, 8'h00, 8'h01);
    apply(2'b01, 6'b100000, 8'h5A, 8'h5A);
    // R3
    apply(2'b10, 6'b100000, 8'h7F, 8'h01);
    apply(2'b11, 6'b100010, 8'h10, 8'h20);
    // R4, R5
    apply(2'b10, 6'b100100, 8'hF0, 8'h0F);
    apply(2'b10, 6'b100101, 8'hA5, 8'h00);
    // R6 corners: equal, less, signed overflow wrap
    apply(2'b10, 6'b101010, 8'h33, 8'h33);
    apply(2'b10, 6'b101010, 8'h80, 8'h01);
    apply(2'b10, 6'b101010, 8'h7F, 8'h80);
    apply(2'b11, 6'b101010, 8'hFE, 8'hFF);
    // R7 unlisted codes
    apply(2'b10, 6'b000000, 8'h12, 8'h34);
    apply(2'b11, 6'b111111, 8'hC0, 8'h40);
    for (int i = 0; i < 600; i++) begin
      logic [5:0] f;
      if ($urandom_range(0, 2) != 0) f = FN[$urandom_range(0, 4)];
      else                           f = 6'($urandom);
      apply(2'($urandom), f, 8'($urandom), ($urandom_range(0, 7) == 0) ? 8'h00 : 8'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule